// File: doc/BRIEF.md
# Sticky Masked Interrupt Latch

This block gathers a word of level-sensitive interrupt lines into a sticky status register and raises one combined interrupt. Software reaches it through a simple 32-bit register port. A write strobe commits data on the clock edge, and read data is decoded from the address in the same cycle.

Every cycle, each line whose mask bit is set is ORed into the status register. A status bit stays set after its line drops and clears only when software writes a 1 to it. One bit of the input word, bit 11, is not taken from the general source vector. It carries the aggregated interrupt line of a downstream controller. The polarity register can be written and read back, but it has no effect on latching.

Top module: `irq_latch_unit`

## Requirements
- R1: After reset, the status, mask and polarity registers read 0 and `irq_out` is low.
- R2: The registers are 32 bits wide at these byte offsets: status 0x50, mask 0x54, polarity 0x58, input 0x5C. A write takes effect on the clock edge where `wr_en` is high.
- R3: The input register returns the current raw line word. Bit 11 of that word is `ctl_irq`, and `src_lines[11]` is ignored.
- R4: On each clock edge, status gains the bitwise AND of the input word and the mask. Lines that are not masked never set status.
- R5: A status bit stays set after its line falls or its mask bit is cleared.
- R6: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged.
- R7: If a clear and a new latch event hit the same bit on the same edge, the bit ends up set.
- R8: `irq_out` is high exactly when at least one status bit is set.
- R9: The polarity register reads back what was written and does not change latching.
- R10: Writes to the input register are ignored.
- R11: A read of any other offset returns all ones. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| src_lines | input | 32 | Level interrupt lines (bit 11 unused) |
| ctl_irq | input | 1 | Aggregated downstream controller interrupt, bit 11 |
| irq_out | output | 1 | Combined interrupt |

## Verification
Each of the 32 bit positions is swept on its own in four phases:
- All lines high with the mask zero, which shows that unmasked lines are blocked.
- A single mask bit set, which shows that exactly that bit latches.
- All lines low, which shows that the bit is sticky.
- A write-one-to-clear, which shows that the combined output falls.

Bit 11 is also driven from the general vector with the controller line low, to confirm where its source comes from. Partial clears, a clear that coincides with a latch, a polarity register set to all ones, writes to the input register and accesses to undecoded offsets each isolate one rule that the plain sweep cannot.

// File: rtl/irq_latch_unit.sv
module irq_latch_unit #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int CTL_BIT = 11,
  parameter logic [AW-1:0] OFS_STAT = 8'h50,
  parameter logic [AW-1:0] OFS_MASK = 8'h54,
  parameter logic [AW-1:0] OFS_POL  = 8'h58,
  parameter logic [AW-1:0] OFS_IN   = 8'h5C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] src_lines,
  input  logic          ctl_irq,
  output logic          irq_out
);
  localparam logic [DW-1:0] ALL1 = {DW{1'b1}};

  logic [DW-1:0] status_q, mask_q, pol_q, in_word, clr;

  always_comb begin
    in_word = src_lines;
    in_word[CTL_BIT] = ctl_irq;
  end

  assign clr = (wr_en && addr == OFS_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      pol_q    <= '0;
    end else begin
      status_q <= (status_q & ~clr) | (in_word & mask_q);
      if (wr_en && addr == OFS_MASK) mask_q <= wdata;
      if (wr_en && addr == OFS_POL)  pol_q  <= wdata;
    end
  end

  always_comb begin
    case (addr)
      OFS_STAT: rdata = status_q;
      OFS_MASK: rdata = mask_q;
      OFS_POL:  rdata = pol_q;
      OFS_IN:   rdata = in_word;
      default:  rdata = ALL1;
    endcase
  end

  assign irq_out = |status_q;
endmodule

module irq_latch_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter logic [AW-1:0] OFS_STAT = 8'h50,
  parameter logic [AW-1:0] OFS_MASK = 8'h54,
  parameter logic [AW-1:0] OFS_POL  = 8'h58,
  parameter logic [AW-1:0] OFS_IN   = 8'h5C
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] in_word,
  input logic [DW-1:0] mask_q,
  input logic          irq_out
);
  // R8
  irq_matches_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_STAT) |-> (irq_out == (rdata != '0)));

  // R5
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out && !(wr_en && addr == OFS_STAT)) |=> irq_out);

  // R4
  masked_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_word & mask_q) != '0) |=> irq_out);

  // R6
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_STAT && wdata == '1 && (in_word & mask_q) == '0) |=> !irq_out);

  // R3
  input_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_IN) |-> (rdata == in_word));

  // R11
  undecoded_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != OFS_STAT && addr != OFS_MASK && addr != OFS_POL && addr != OFS_IN) |-> (rdata == '1));
endmodule

bind irq_latch_unit irq_latch_unit_chk #(
  .DW(DW), .AW(AW), .OFS_STAT(OFS_STAT), .OFS_MASK(OFS_MASK),
  .OFS_POL(OFS_POL), .OFS_IN(OFS_IN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .in_word(in_word), .mask_q(mask_q), .irq_out(irq_out)
);

// File: tb/test_irq_latch_unit.sv
module test_irq_latch_unit;
  localparam logic [7:0] A_STAT = 8'h50, A_MASK = 8'h54, A_POL = 8'h58, A_IN = 8'h5C;

  logic clk = 0, rst_n = 0, wr_en = 0, ctl_irq = 0;
  logic [7:0] addr = A_STAT;
  logic [31:0] wdata = 0, src_lines = 0, rdata;
  logic irq_out;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  irq_latch_unit i_irq_latch_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .src_lines(src_lines), .ctl_irq(ctl_irq), .irq_out(irq_out)
  );

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0; addr = A_STAT;
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; #2;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string req);
    #1; checks++;
    if (irq_out !== exp) begin
      errors++;
      $display("FAIL %s irq_out actual=%b expected=%b", req, irq_out, exp);
    end
  endtask

  initial begin
    #3000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk_rd(A_STAT, 32'h0, "R1");
    chk_rd(A_MASK, 32'h0, "R1");
    chk_rd(A_POL, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R2/R4/R5/R6/R8 per-bit sweep
    for (int i = 0; i < 32; i++) begin
      src_lines = 32'hFFFF_FFFF; ctl_irq = 1;
      wr(A_MASK, 32'h0);
      wr(A_STAT, 32'hFFFF_FFFF);
      chk_rd(A_STAT, 32'h0, "R4 unmasked");
      wr(A_MASK, 32'h1 << i);
      chk_rd(A_MASK, 32'h1 << i, "R2");
      chk_rd(A_STAT, 32'h1 << i, "R4 latch");
      chk_irq(1'b1, "R8 set");
      src_lines = 0; ctl_irq = 0;
      repeat (2) @(negedge clk);
      chk_rd(A_STAT, 32'h1 << i, "R5 sticky");
      wr(A_STAT, 32'h1 << i);
      chk_rd(A_STAT, 32'h0, "R6 clear");
      chk_irq(1'b0, "R8 clear");
    end

    // R3 bit 11 taken from ctl_irq only
    wr(A_MASK, 32'h800);
    src_lines = 32'h800; ctl_irq = 0;
    chk_rd(A_IN, 32'h0, "R3 src11 ignored");
    chk_rd(A_STAT, 32'h0, "R3 no latch");
    src_lines = 32'h0000_0400; ctl_irq = 1;
    chk_rd(A_IN, 32'h0000_0C00, "R3 ctl bit");
    chk_rd(A_STAT, 32'h800, "R3 latch");
    ctl_irq = 0; src_lines = 0;
    wr(A_STAT, 32'hFFFF_FFFF);

    // R6 partial clear
    wr(A_MASK, 32'hF);
    src_lines = 32'hF; @(negedge clk); src_lines = 0;
    chk_rd(A_STAT, 32'hF, "R6 setup");
    wr(A_STAT, 32'h5);
    chk_rd(A_STAT, 32'hA, "R6 partial");
    wr(A_STAT, 32'hA);
    chk_rd(A_STAT, 32'h0, "R6 rest");

    // R7 clear collides with latch
    src_lines = 32'h8;
    wr(A_STAT, 32'h8);
    src_lines = 0;
    chk_rd(A_STAT, 32'h8, "R7");
    wr(A_STAT, 32'h8);
    chk_rd(A_STAT, 32'h0, "R7 after");

    // R9 polarity storage only
    wr(A_POL, 32'hFFFF_FFFF);
    chk_rd(A_POL, 32'hFFFF_FFFF, "R9 readback");
    src_lines = 32'h2; @(negedge clk); src_lines = 0;
    chk_rd(A_STAT, 32'h2, "R9 latch unchanged");
    chk_rd(A_STAT, 32'h2, "R9 no latch on low");
    wr(A_STAT, 32'hFFFF_FFFF);
    wr(A_POL, 32'h1234_5678);
    chk_rd(A_POL, 32'h1234_5678, "R9 readback2");

    // R10 input register write ignored
    wr(A_IN, 32'hFFFF_FFFF);
    chk_rd(A_IN, 32'h0, "R10");
    chk_rd(A_STAT, 32'h0, "R10 status");
    chk_rd(A_MASK, 32'hF, "R10 mask");

    // R11 undecoded offsets
    chk_rd(8'h60, 32'hFFFF_FFFF, "R11 read 0x60");
    chk_rd(8'h00, 32'hFFFF_FFFF, "R11 read 0x00");
    chk_rd(8'h52, 32'hFFFF_FFFF, "R11 read 0x52");
    wr(8'h60, 32'hFFFF_FFFF);
    wr(8'h51, 32'hFFFF_FFFF);
    chk_rd(A_MASK, 32'hF, "R11 mask kept");
    chk_rd(A_POL, 32'h1234_5678, "R11 pol kept");
    chk_rd(A_STAT, 32'h0, "R11 stat kept");

    // R1 reset again clears everything
    src_lines = 32'h1; @(negedge clk); src_lines = 0;
    rst_n = 0; @(negedge clk); rst_n = 1;
    chk_rd(A_STAT, 32'h0, "R1 rereset");
    chk_rd(A_MASK, 32'h0, "R1 rereset");
    chk_rd(A_POL, 32'h0, "R1 rereset");
    chk_irq(1'b0, "R1 rereset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule